// File: doc/BRIEF.md
# Recovering Store Address Matcher

This block repairs a speculative load that faulted earlier and was logged in a table of deferred-fault slots. Each slot holds a valid bit, a captured load address, the destination register index of the load and a bit that says whether that destination sits in the floating-point or the integer register file. When a store comes by, the block scans the slots for one whose captured address equals the store address. If one is found, it sends the stored data into the logged destination register, one 32-bit word per cycle, and asks the data cache to flush and invalidate the line that holds the address.

The store presents its address, a size code and up to four source data words at once, with a one-cycle strobe. The block keeps the data words internally, so the caller may change its inputs after the strobe. Register writes come out as a write enable with index, file select and data. A one-cycle done pulse marks the end of each accepted store, whether it matched or not.

Top module: `rsm_top`

## Requirements
- R1: A slot whose valid bit is 0 never matches, even when its address equals the store address.
- R2: When several usable slots match, only the one with the lowest index is acted on.
- R3: On a match, `inv_req` pulses for exactly one cycle, together with the first register write, and `inv_addr` carries the store address.
- R4: Size code 3 (8 bytes) gives two word writes and code 4 (16 bytes) gives four. Codes 5 to 7 behave as code 4. Write k carries source word k (bits 32k+31:32k of `st_data`) to destination index dst+k, which wraps modulo the index range.
- R5: Size code 0 (1 byte) masks the written word to bits 7:0 and code 1 (2 bytes) masks it to bits 15:0. Code 2 (4 bytes) writes the word unmasked, as one write.
- R6: `rf_fp` equals the float bit of the matched slot on every write of that store.
- R7: Slots whose index is greater than or equal to `slot_lim` are ignored.
- R8: With no match, no write and no invalidate occur, and `done` pulses in the cycle after the strobe.
- R9: A strobe that arrives while `busy` is high is ignored. It produces no write, no invalidate and no done.
- R10: The first write appears in the cycle after the strobe, and the remaining writes follow one per cycle. `done` is high together with the last write.
- R11: After reset, `rf_we`, `inv_req`, `done` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store strobe, one cycle |
| st_addr | input | AW | Store address |
| st_size | input | 3 | Size code: 0=1B, 1=2B, 2=4B, 3=8B, 4..7=16B |
| st_data | input | MAXW*32 | Source data words, word 0 in the low bits |
| slot_lim | input | CW | Number of slots in use |
| slot_valid | input | NSLOT | Valid bit for each slot |
| slot_fp | input | NSLOT | Float-file bit for each slot |
| slot_addr | input | NSLOT*AW | Captured address for each slot |
| slot_dst | input | NSLOT*RW | Logged destination index for each slot |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | RW | Register write index |
| rf_fp | output | 1 | 1 selects the float file, 0 the integer file |
| rf_wdata | output | 32 | Register write data |
| inv_req | output | 1 | Flush-and-invalidate request for the cache line |
| inv_addr | output | AW | Address for the invalidate |
| done | output | 1 | End of an accepted store |
| busy | output | 1 | Words of the copy are still pending |

## Verification
A corrupted word counter shows at the ports within the same store: the number of writes before `done` is wrong, or `busy` stays high when it should have dropped, and the next store's strobe is then dropped. A wrong priority or slot-limit decision shows on the first write as the wrong destination index or file select, in the cycle right after the strobe. A stale shift register for the data words shows as the wrong data on the second or a later write of a multiword copy.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2,
        SZ_DUAL = 3'd3,
        SZ_QUAD = 3'd4
    } size_code_e;
endpackage

// File: rtl/rsm_size_dec.sv
module rsm_size_dec #(
    parameter int MAXW = 4,
    localparam int LW = $clog2(MAXW + 1)
) (
    input  logic [2:0]  size,
    output logic [LW-1:0] nwords,
    output logic [31:0] mask
);
    import rsm_pkg::*;

    int raw;

    always_comb begin
        mask = 32'hFFFF_FFFF;
        case (size_code_e'(size))
            SZ_BYTE: begin raw = 1; mask = 32'h0000_00FF; end
            SZ_HALF: begin raw = 1; mask = 32'h0000_FFFF; end
            SZ_WORD: raw = 1;
            SZ_DUAL: raw = 2;
            default: raw = 4;
        endcase
        if (raw > MAXW) raw = MAXW;
        nwords = LW'(raw);
    end
endmodule

// File: rtl/rsm_match.sv
module rsm_match #(
    parameter int NSLOT = 4,
    parameter int AW    = 32,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CW   = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     st_addr,
    input  logic [CW-1:0]     slot_lim,
    input  logic [NSLOT-1:0]  slot_valid,
    input  logic [NSLOT*AW-1:0] slot_addr,
    output logic              hit,
    output logic [IW-1:0]     hit_idx
);
    logic [NSLOT-1:0] cand;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign cand[g] = slot_valid[g]
                       && (slot_addr[g*AW +: AW] == st_addr)
                       && (CW'(g) < slot_lim);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    p_hit_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> slot_valid[hit_idx]);

    p_hit_in_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (32'(hit_idx) < 32'(slot_lim)));
endmodule

// File: rtl/rsm_top.sv
module rsm_top #(
    parameter int NSLOT = 4,
    parameter int AW    = 32,
    parameter int RW    = 6,
    parameter int MAXW  = 4,
    localparam int IW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CW   = $clog2(NSLOT + 1),
    localparam int LW   = $clog2(MAXW + 1),
    localparam int DW   = MAXW * 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    input  logic [AW-1:0]        st_addr,
    input  logic [2:0]           st_size,
    input  logic [DW-1:0]        st_data,
    input  logic [CW-1:0]        slot_lim,
    input  logic [NSLOT-1:0]     slot_valid,
    input  logic [NSLOT-1:0]     slot_fp,
    input  logic [NSLOT*AW-1:0]  slot_addr,
    input  logic [NSLOT*RW-1:0]  slot_dst,
    output logic                 rf_we,
    output logic [RW-1:0]        rf_idx,
    output logic                 rf_fp,
    output logic [31:0]          rf_wdata,
    output logic                 inv_req,
    output logic [AW-1:0]        inv_addr,
    output logic                 done,
    output logic                 busy
);
    typedef struct packed {
        logic [LW-1:0] left;
        logic [DW-1:0] data;
        logic          we;
        logic [RW-1:0] idx;
        logic          fp;
        logic [31:0]   wdata;
        logic          inv;
        logic [AW-1:0] iaddr;
        logic          done;
    } state_t;

    state_t s_d, s_q;

    logic          hit;
    logic [IW-1:0] hit_idx;
    logic [LW-1:0] nwords;
    logic [31:0]   mask;

    rsm_match #(.NSLOT(NSLOT), .AW(AW)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_addr    (st_addr),
        .slot_lim   (slot_lim),
        .slot_valid (slot_valid),
        .slot_addr  (slot_addr),
        .hit        (hit),
        .hit_idx    (hit_idx)
    );

    rsm_size_dec #(.MAXW(MAXW)) u_size (
        .size   (st_size),
        .nwords (nwords),
        .mask   (mask)
    );

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        s_d.inv  = 1'b0;
        s_d.done = 1'b0;
        if (s_q.left != '0) begin
            s_d.we    = 1'b1;
            s_d.idx   = s_q.idx + 1'b1;
            s_d.wdata = s_q.data[31:0];
            s_d.data  = s_q.data >> 32;
            s_d.left  = s_q.left - 1'b1;
            s_d.done  = (s_q.left == LW'(1));
        end else if (st_valid) begin
            if (hit) begin
                s_d.we    = 1'b1;
                s_d.idx   = slot_dst[hit_idx*RW +: RW];
                s_d.fp    = slot_fp[hit_idx];
                s_d.wdata = st_data[31:0] & mask;
                s_d.data  = st_data >> 32;
                s_d.left  = nwords - 1'b1;
                s_d.inv   = 1'b1;
                s_d.iaddr = st_addr;
                s_d.done  = (nwords == LW'(1));
            end else begin
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rf_we    = s_q.we;
    assign rf_idx   = s_q.idx;
    assign rf_fp    = s_q.fp;
    assign rf_wdata = s_q.wdata;
    assign inv_req  = s_q.inv;
    assign inv_addr = s_q.iaddr;
    assign done     = s_q.done;
    assign busy     = (s_q.left != '0);

    p_inv_with_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> rf_we);

    p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !done) |=> (rf_we && !inv_req
                              && rf_idx == RW'($past(rf_idx) + 1'b1)
                              && rf_fp == $past(rf_fp)));

    p_nomatch_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !busy && !hit) |=> (done && !rf_we && !inv_req));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && busy) |=> !inv_req);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/rsm_top_test.sv
module rsm_top_test;
    localparam int NSLOT = 4;
    localparam int AW    = 32;
    localparam int RW    = 6;
    localparam int MAXW  = 4;
    localparam int CW    = $clog2(NSLOT + 1);
    localparam int DW    = MAXW * 32;

    typedef struct {
        logic          we;
        logic [RW-1:0] idx;
        logic          fp;
        logic [31:0]   data;
        logic          inv;
        logic [AW-1:0] iaddr;
        logic          done;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [2:0] st_size = '0;
    logic [DW-1:0] st_data = '0;
    logic [CW-1:0] slot_lim = CW'(NSLOT);
    logic [NSLOT-1:0] slot_valid = '0;
    logic [NSLOT-1:0] slot_fp = '0;
    logic [AW-1:0] b_addr [NSLOT];
    logic [RW-1:0] b_dst [NSLOT];
    logic [NSLOT*AW-1:0] slot_addr;
    logic [NSLOT*RW-1:0] slot_dst;

    logic rf_we, rf_fp, inv_req, done, busy;
    logic [RW-1:0] rf_idx;
    logic [31:0] rf_wdata;
    logic [AW-1:0] inv_addr;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            slot_addr[i*AW +: AW] = b_addr[i];
            slot_dst[i*RW +: RW]  = b_dst[i];
        end
    end

    rsm_top #(.NSLOT(NSLOT), .AW(AW), .RW(RW), .MAXW(MAXW)) uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data), .slot_lim(slot_lim),
        .slot_valid(slot_valid), .slot_fp(slot_fp), .slot_addr(slot_addr),
        .slot_dst(slot_dst), .rf_we(rf_we), .rf_idx(rf_idx), .rf_fp(rf_fp),
        .rf_wdata(rf_wdata), .inv_req(inv_req), .inv_addr(inv_addr),
        .done(done), .busy(busy)
    );

    // monitor: pops one expected item for every cycle with activity
    always @(negedge clk) begin
        if (rst_n && (rf_we || inv_req || done)) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL unexpected activity (R9/R8): we=%0b inv=%0b done=%0b expected none",
                         rf_we, inv_req, done);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (rf_we !== e.we || inv_req !== e.inv || done !== e.done
                    || (e.we && (rf_idx !== e.idx || rf_fp !== e.fp || rf_wdata !== e.data))
                    || (e.inv && inv_addr !== e.iaddr)) begin
                    errors++;
                    $display("FAIL %s: got we=%0b idx=%0d fp=%0b data=%h inv=%0b ia=%h done=%0b exp we=%0b idx=%0d fp=%0b data=%h inv=%0b ia=%h done=%0b",
                             e.tag, rf_we, rf_idx, rf_fp, rf_wdata, inv_req, inv_addr, done,
                             e.we, e.idx, e.fp, e.data, e.inv, e.iaddr, e.done);
                end
            end
        end
    end

    function automatic int words_of(int sz);
        if (sz == 3) return 2;
        if (sz >= 4) return 4;
        return 1;
    endfunction

    // driver: computes the expected items from the requirements
    task automatic push_expected(input logic [AW-1:0] a, input int sz,
                                 input logic [DW-1:0] d, input string tag);
        int hit_i = -1;
        for (int i = 0; i < NSLOT; i++)
            if (hit_i < 0 && i < int'(slot_lim) && slot_valid[i] && b_addr[i] == a)
                hit_i = i;
        if (hit_i < 0) begin
            exp_t e;
            e = '{we:0, idx:0, fp:0, data:0, inv:0, iaddr:0, done:1, tag:tag};
            q.push_back(e);
        end else begin
            int n = words_of(sz);
            for (int k = 0; k < n; k++) begin
                exp_t e;
                logic [31:0] w = d[k*32 +: 32];
                if (sz == 0) w &= 32'hFF;
                if (sz == 1) w &= 32'hFFFF;
                e = '{we:1, idx:RW'(int'(b_dst[hit_i]) + k), fp:slot_fp[hit_i],
                      data:w, inv:(k == 0), iaddr:a, done:(k == n - 1), tag:tag};
                q.push_back(e);
            end
        end
    endtask

    task automatic store(input logic [AW-1:0] a, input int sz,
                         input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        st_addr = a; st_size = 3'(sz); st_data = d;
        push_expected(a, sz, d, tag);
        st_valid = 1'b1;
        @(negedge clk);
        st_valid = 1'b0;
        st_data = '1;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [DW-1:0] DATA = {32'hDDDD_4444, 32'hCCCC_3333,
                                      32'hBBBB_2222, 32'hA5A5_1111};

    initial begin
        b_addr[0] = 32'h1000; b_dst[0] = 6'd5;
        b_addr[1] = 32'h2000; b_dst[1] = 6'd10;
        b_addr[2] = 32'h3000; b_dst[2] = 6'd62;
        b_addr[3] = 32'h2000; b_dst[3] = 6'd20;
        slot_valid = 4'b1111;
        slot_fp    = 4'b0100;
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (rf_we !== 0 || inv_req !== 0 || done !== 0 || busy !== 0) begin
            errors++;
            $display("FAIL R11 reset: we=%0b inv=%0b done=%0b busy=%0b exp 0", rf_we, inv_req, done, busy);
        end
        rst_n = 1'b1;

        store(32'h1000, 2, DATA, "R3/R10 word store");
        store(32'h1000, 0, DATA, "R5 byte mask");
        store(32'h1000, 1, DATA, "R5 half mask");
        store(32'h3000, 3, DATA, "R4/R6 dual float");
        store(32'h3000, 4, DATA, "R4 quad wrap");
        store(32'h1000, 6, DATA, "R4 code 6 as quad");
        store(32'h2000, 2, DATA, "R2 lowest index");
        slot_valid = 4'b1101;
        store(32'h2000, 2, DATA, "R1 invalid skipped");
        slot_valid = 4'b0101;
        store(32'h2000, 2, DATA, "R1 none valid");
        slot_valid = 4'b1111;
        slot_lim = CW'(2);
        store(32'h3000, 2, DATA, "R7 beyond limit");
        slot_lim = CW'(NSLOT);
        store(32'h4444, 2, DATA, "R8 no match");

        // R9: second strobe during a quad copy must be ignored
        @(negedge clk);
        st_addr = 32'h3000; st_size = 3'd4; st_data = DATA;
        push_expected(32'h3000, 4, DATA, "R9 copy in progress");
        st_valid = 1'b1;
        @(negedge clk);
        st_addr = 32'h1000; st_size = 3'd2;
        @(negedge clk);
        st_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0) begin
            errors++;
            $display("FAIL R9 busy after copy: got %0b exp 0", busy);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule